// File: doc/BRIEF.md
# Hall Position Decoder and Monitor

This block takes the three Hall-effect position lines of a three-phase brushless motor, removes short glitches from each line, and turns the resulting three-bit code into an electrical sector number from 0 to 5. It gives a motor controller what it needs to commutate and supervise the machine. It produces a tachometer output with three pulses per electrical revolution. It flags rotation that runs against the commanded direction. It raises a gate-block request whenever the sensors report one of the two impossible codes.

The block also times every sector with a free-running counter. It uses the last measured sector duration to interpolate a fine angle inside the current sector. A PWM waveform generator can then read a smooth electrical angle, formed from the sector number and a fraction, instead of six coarse steps.

Top module: `hall_sector_tracker`

## Requirements
- R1: Each Hall line passes a two-flop synchronizer and is then accepted only after the synchronized level has differed from the accepted level for FILT_CYCLES consecutive clocks. A pulse of fewer than FILT_CYCLES clocks leaves the accepted level, and so every output, unchanged.
- R2: With the code written {hall_w, hall_v, hall_u}, the legal codes map to sectors as follows: 001 is 0, 011 is 1, 010 is 2, 110 is 3, 100 is 4 and 101 is 5. `sector` shows the sector of the last legal accepted code.
- R3: The accepted codes 000 and 111 drive `gate_block` high while `sector` keeps its last legal value. `gate_block` returns low once a legal code is accepted again.
- R4: `fg` is 1 while `sector` is odd and 0 while it is even. One pass through the six sectors therefore produces exactly 3 `fg` pulses.
- R5: `dir_rev` = 0 commands forward rotation, in which the sector number increases by one modulo 6 per step. `dir_rev` = 1 commands reverse rotation, in which it decreases by one modulo 6.
- R6: `rev` is set by a one-sector step opposite to the commanded direction and cleared by a one-sector step in the commanded direction. A jump of more than one sector leaves it unchanged.
- R7: The sector period P is the number of clocks between two consecutive accepted sector changes. When P >= 2^FRAC_W, the fraction `angle[FRAC_W-1:0]` equals min(floor(n*2^FRAC_W/P), 2^FRAC_W-1) n clocks after the internal restart that follows a sector change. `angle[FRAC_W+2:FRAC_W]` equals `sector`.
- R8: After reset, `sector` = 0, `angle` = 0, `fg` = 0, `rev` = 0 and `gate_block` = 1, because the accepted code is 000.
- R9: The first legal code accepted after reset sets `sector` and makes no judgement on direction, so `rev` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hall_u | input | 1 | Hall line U (raw) |
| hall_v | input | 1 | Hall line V (raw) |
| hall_w | input | 1 | Hall line W (raw) |
| dir_rev | input | 1 | Commanded direction, 0 forward, 1 reverse |
| sector | output | 3 | Current electrical sector 0..5 |
| angle | output | FRAC_W+3 | Sector number above the interpolated fraction |
| fg | output | 1 | Tachometer, 3 pulses per electrical revolution |
| rev | output | 1 | Rotation opposite to the command |
| gate_block | output | 1 | Illegal Hall code, block the gates |

## Verification
The bench builds the block with FILT_CYCLES = 4, PER_W = 12 and FRAC_W = 4. With these values a 2-clock glitch falls clearly below the filter threshold. A 40-clock sector period also exceeds the 16 fraction steps, so the exact floor values at several offsets can be predicted. Holding a sector for longer than its measured period then brings fraction saturation within reach in a few hundred clocks. Direction, reverse-flag, jump and fault sequences are applied as whole-code changes and sampled after the fixed filter latency has settled.

// File: rtl/hall_pkg.sv
// Shared types and helpers for the Hall position decoder.
// Assumes codes are packed {w, v, u}.
package hall_pkg;

    typedef logic [2:0] sector_t;

    typedef struct packed {
        logic    ok;
        sector_t sec;
    } decode_t;

    // Map a Hall code to its sector; ok is low for 000 and 111.
    function automatic decode_t decode_code(input logic [2:0] code);
        decode_t d;
        d.ok  = 1'b1;
        d.sec = 3'd0;
        case (code)
            3'b001: d.sec = 3'd0;
            3'b011: d.sec = 3'd1;
            3'b010: d.sec = 3'd2;
            3'b110: d.sec = 3'd3;
            3'b100: d.sec = 3'd4;
            3'b101: d.sec = 3'd5;
            default: d.ok = 1'b0;
        endcase
        return d;
    endfunction

    // Next sector in the forward sense, modulo 6.
    function automatic sector_t sec_inc(input sector_t s);
        return (s == 3'd5) ? 3'd0 : s + 3'd1;
    endfunction

    // Next sector in the reverse sense, modulo 6.
    function automatic sector_t sec_dec(input sector_t s);
        return (s == 3'd0) ? 3'd5 : s - 3'd1;
    endfunction

endpackage

// File: rtl/hall_deglitch.sv
// Synchronizes one Hall line and accepts a new level only after it has
// been stable for FILT_CYCLES clocks. Assumes FILT_CYCLES >= 2.
module hall_deglitch #(
    parameter int FILT_CYCLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    logic          sync1, sync2;
    logic [CW-1:0] cnt;

    // Two-flop synchronizer against metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= din;
            sync2 <= sync1;
        end
    end

    // Stability counter: take the new level once it has persisted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            dout <= 1'b0;
        end else if (sync2 == dout) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            dout <= sync2;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1: an accepted change always follows the synchronized level.
    a_r1_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (dout != $past(dout)) |-> ($past(sync2) == dout));

endmodule

// File: rtl/hall_state_monitor.sv
// Decodes the filtered Hall code into a sector and judges direction.
// It drives fg, rev and gate_block, and issues a restart pulse on every
// accepted sector change. Assumes the code input is already deglitched.
module hall_state_monitor
    import hall_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  code,
    input  logic        dir_rev,
    output sector_t     sector_q,
    output logic        fg,
    output logic        rev,
    output logic        gate_block,
    output logic        restart
);
    decode_t dec;
    logic    have_ref;
    logic    changed, step_fwd, step_bwd, adj_step, against;

    // Classify the incoming code against the held sector.
    always_comb begin
        dec      = decode_code(code);
        changed  = dec.ok && (!have_ref || dec.sec != sector_q);
        step_fwd = dec.ok && have_ref && (dec.sec == sec_inc(sector_q));
        step_bwd = dec.ok && have_ref && (dec.sec == sec_dec(sector_q));
        adj_step = step_fwd || step_bwd;
        against  = dir_rev ? step_fwd : step_bwd;
    end

    // Sector, tachometer and restart pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sector_q <= 3'd0;
            fg       <= 1'b0;
            have_ref <= 1'b0;
            restart  <= 1'b0;
        end else begin
            restart <= changed;
            if (dec.ok) begin
                sector_q <= dec.sec;
                fg       <= dec.sec[0];
                have_ref <= 1'b1;
            end
        end
    end

    // Reverse flag: only one-sector steps are judged.
    always_ff @(posedge clk) begin
        if (!rst_n)        rev <= 1'b0;
        else if (adj_step) rev <= against;
    end

    // Gate-block request for the two illegal codes.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_block <= 1'b1;
        else        gate_block <= !dec.ok;
    end

    // R2: the reported sector is always a legal number.
    a_r2_sector_legal: assert property (@(posedge clk) disable iff (!rst_n)
        sector_q < 3'd6);

    // R3: an illegal code yields a block request on the next cycle.
    a_r3_bad_code_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 3'b000 || code == 3'b111) |=> gate_block);

    // R3: while blocked the sector holds.
    a_r3_sector_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 3'b000 || code == 3'b111) |=> $stable(sector_q));

    // R6: rev can only rise after a one-sector step.
    a_r6_rev_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rev) |-> $past(adj_step));

endmodule

// File: rtl/hall_angle_interp.sv
// Measures each sector's length in clocks and interpolates a fraction
// within the following sector from that length. Assumes the period is
// at least 2^FRAC_W clocks for exact steps; shorter periods lag.
module hall_angle_interp #(
    parameter int PER_W  = 20,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    output logic [FRAC_W-1:0] frac_q
);
    localparam int AW = PER_W + 2;
    localparam logic [PER_W-1:0]  CNT_MAX  = '1;
    localparam logic [FRAC_W-1:0] FRAC_MAX = '1;
    localparam logic [AW-1:0]     STEP     = AW'(1) << FRAC_W;

    logic [PER_W-1:0] cnt, period_q;
    logic [AW-1:0]    acc, acc_sum;
    logic             carry;

    // Accumulator sum and carry toward the next fraction step.
    always_comb begin
        acc_sum = acc + STEP;
        carry   = (period_q != '0) && (acc_sum >= AW'(period_q));
    end

    // Sector timer and period capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            period_q <= '0;
        end else if (restart) begin
            period_q <= (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;
            cnt      <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Fraction accumulator, saturating at its top value.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            acc    <= '0;
            frac_q <= '0;
        end else if (period_q != '0) begin
            if (carry) begin
                acc <= acc_sum - AW'(period_q);
                if (frac_q != FRAC_MAX) frac_q <= frac_q + 1'b1;
            end else begin
                acc <= acc_sum;
            end
        end
    end

    // R7: within a sector the fraction never decreases.
    a_r7_frac_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> frac_q >= $past(frac_q));

    // R7: a restart clears the fraction.
    a_r7_frac_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> frac_q == '0);

endmodule

// File: rtl/hall_sector_tracker.sv
// Top level: three deglitched Hall lines feed the sector monitor and the
// angle interpolator. Assumes raw Hall inputs are asynchronous.
module hall_sector_tracker #(
    parameter int FILT_CYCLES = 25,
    parameter int PER_W       = 20,
    parameter int FRAC_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hall_u,
    input  logic              hall_v,
    input  logic              hall_w,
    input  logic              dir_rev,
    output logic [2:0]        sector,
    output logic [FRAC_W+2:0] angle,
    output logic              fg,
    output logic              rev,
    output logic              gate_block
);
    localparam int LINES = 3;

    logic [LINES-1:0]  raw, clean;
    logic              restart;
    logic [FRAC_W-1:0] frac;

    assign raw = {hall_w, hall_v, hall_u};

    // One deglitch filter per Hall line.
    for (genvar i = 0; i < LINES; i++) begin : g_filt
        hall_deglitch #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[i]),
            .dout (clean[i])
        );
    end

    hall_state_monitor u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .code      (clean),
        .dir_rev   (dir_rev),
        .sector_q  (sector),
        .fg        (fg),
        .rev       (rev),
        .gate_block(gate_block),
        .restart   (restart)
    );

    hall_angle_interp #(.PER_W(PER_W), .FRAC_W(FRAC_W)) u_interp (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .frac_q (frac)
    );

    assign angle = {sector, frac};

endmodule

// File: tb/hall_sector_tracker_test.sv
// Directed bench for the Hall position decoder.
module hall_sector_tracker_test;
    localparam int CLK_PERIOD = 10;
    localparam int FILT   = 4;
    localparam int FRAC_W = 4;
    localparam int SETTLE = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] hall = 3'b000;
    logic dir_rev = 1'b0;
    logic [2:0] sector;
    logic [FRAC_W+2:0] angle;
    logic fg, rev, gate_block;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hall_sector_tracker #(.FILT_CYCLES(FILT), .PER_W(12), .FRAC_W(FRAC_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .hall_u(hall[0]), .hall_v(hall[1]), .hall_w(hall[2]),
        .dir_rev(dir_rev),
        .sector(sector), .angle(angle), .fg(fg), .rev(rev),
        .gate_block(gate_block)
    );

    // Code for each sector, written {w, v, u}, per R2.
    function automatic logic [2:0] code_of(input int s);
        case (s)
            0: return 3'b001;
            1: return 3'b011;
            2: return 3'b010;
            3: return 3'b110;
            4: return 3'b100;
            default: return 3'b101;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] c);
        @(negedge clk);
        hall = c;
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic go_sector(input int s);
        drive(code_of(s));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        hall = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sector == 0, "R8 sector", sector, 0);
        check(angle == 0, "R8 angle", angle, 0);
        check(fg == 0 && rev == 0, "R8 fg/rev", {fg, rev}, 0);
        check(gate_block == 1, "R8 gate_block", gate_block, 1);
    endtask

    task automatic t_first_code;
        dir_rev = 1'b1;
        go_sector(1);
        check(sector == 1, "R9 sector", sector, 1);
        check(rev == 0, "R9 rev", rev, 0);
        check(gate_block == 0, "R3 released", gate_block, 0);
    endtask

    task automatic t_forward_cycle;
        int pulses = 0;
        logic last_fg;
        dir_rev = 1'b0;
        go_sector(2);
        last_fg = fg;
        for (int k = 3; k < 9; k++) begin
            go_sector(k % 6);
            check(sector == 3'(k % 6), "R2 sector", sector, k % 6);
            check(fg == 1'((k % 6) & 1), "R4 fg parity", fg, (k % 6) & 1);
            check(rev == 0, "R5 forward no rev", rev, 0);
            if (fg && !last_fg) pulses++;
            last_fg = fg;
        end
        check(pulses == 3, "R4 pulses per cycle", pulses, 3);
    endtask

    task automatic t_rev_detect;
        dir_rev = 1'b0;
        go_sector(1);
        check(rev == 1, "R6 backward step sets", rev, 1);
        go_sector(4);
        check(rev == 1 && sector == 4, "R6 jump keeps", rev, 1);
        go_sector(5);
        check(rev == 0, "R6 forward step clears", rev, 0);
    endtask

    task automatic t_reverse_cmd;
        dir_rev = 1'b1;
        go_sector(4);
        check(rev == 0, "R5 reverse command decreasing", rev, 0);
        go_sector(3);
        check(rev == 0 && sector == 3, "R5 reverse step ok", sector, 3);
        go_sector(4);
        check(rev == 1, "R5 increasing under reverse", rev, 1);
        go_sector(3);
        check(rev == 0, "R6 cleared in reverse", rev, 0);
    endtask

    task automatic t_glitch;
        @(negedge clk);
        hall = code_of(3) ^ 3'b001;
        repeat (FILT - 2) @(negedge clk);
        hall = code_of(3);
        repeat (SETTLE) @(negedge clk);
        check(sector == 3, "R1 glitch ignored", sector, 3);
        check(gate_block == 0 && rev == 0, "R1 glitch no flag", {gate_block, rev}, 0);
    endtask

    task automatic t_fault;
        drive(3'b000);
        check(gate_block == 1, "R3 code 000", gate_block, 1);
        check(sector == 3, "R3 sector held", sector, 3);
        drive(3'b111);
        check(gate_block == 1, "R3 code 111", gate_block, 1);
        go_sector(3);
        check(gate_block == 0, "R3 released", gate_block, 0);
    endtask

    task automatic t_interp;
        localparam int P = 40;
        int exp_f;
        dir_rev = 1'b0;
        go_sector(0);
        @(negedge clk);
        hall = code_of(1);
        repeat (P) @(negedge clk);
        hall = code_of(2);
        while (sector != 3'd2) @(negedge clk);
        @(negedge clk);
        check(angle[FRAC_W+2:FRAC_W] == 2, "R7 upper bits", angle[FRAC_W+2:FRAC_W], 2);
        for (int n = 1; n <= 60; n++) begin
            @(negedge clk);
            exp_f = (n * 16) / P;
            if (exp_f > 15) exp_f = 15;
            if (n == 10 || n == 25 || n == 39 || n == 60)
                check(angle[FRAC_W-1:0] == 4'(exp_f), "R7 fraction",
                      angle[FRAC_W-1:0], exp_f);
        end
    endtask

    initial begin
        t_reset();
        t_first_code();
        t_forward_cycle();
        t_rev_detect();
        t_reverse_cmd();
        t_glitch();
        t_fault();
        t_interp();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule